// File: doc/BRIEF.md
# Vertical Sync Separator

The block pulls a vertical sync level out of a composite or horizontal sync stream. It runs on a slow sample clock of its own, nominally near 5 MHz and independent of any pixel clock. A change on the sync input must persist for a programmable number of sample periods before it reaches the output. Short horizontal pulses die out inside the filter, and only the long vertical interval gets through.

The raw sync level first crosses into the sample domain through a flip-flop chain. A run counter then measures how long the synchronised level has disagreed with the present output. Whenever the two agree, the counter restarts. When the count reaches the 8-bit threshold, the output takes the input level and the counter clears. The threshold must be set above the widest horizontal pulse, counted in sample periods. A typical setting is 32.

Top module: `vsync_separator`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `vsync_out` is 0 (the `OUT_INIT` default) and the run count is zero. The output does not move until a filtered change arrives.
- R2: The raw input passes through two sample-clock flip-flops. With `thr_cycles` = 0, a raw level set up before rising edge k and differing from the output appears on `vsync_out` after edge k+2.
- R3: With threshold T, a raw level that differs from the output and is held from edge k onward appears on `vsync_out` after edge k+2+T.
- R4: A raw pulse that lasts T sample periods or fewer never changes `vsync_out`. This holds at the boundary of exactly T periods.
- R5: A raw pulse that lasts T+1 sample periods changes `vsync_out`. This holds for a high-going pulse and for a low-going pulse.
- R6: Any sample in which the synchronised input equals the output restarts the count. Pulses split by a one-period gap do not add up.
- R7: The count clears in the cycle the output changes. A return to the previous level needs its own T+1 periods.
- R8: The full 8-bit range works. With T = 255, a 255-period pulse is rejected and a 256-period pulse is accepted. A count above T lasts at most one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sample | input | 1 | Slow sample clock, near 5 MHz |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_raw | input | 1 | Raw composite or horizontal sync level, asynchronous |
| thr_cycles | input | THR_W (8) | Number of sample periods a change must persist, minus one |
| vsync_out | output | 1 | Filtered vertical sync level |

## Verification
The checker relies on `thr_cycles` changing only while the synchronised input agrees with the output. In that state the count is zero and no run is in progress. The bench changes the threshold only after holding the input at the modelled output level for several periods. The bench drives `sync_raw` for whole sample periods. Pulse widths are therefore exact period counts, which the R4, R5 and R8 boundaries depend on.

// File: rtl/vsep_pkg.sv
`timescale 1ns/1ps
package vsep_pkg;

   typedef enum logic [1:0] {
      ACT_IDLE  = 2'd0,
      ACT_COUNT = 2'd1,
      ACT_FLIP  = 2'd2
   } vsep_act_e;

   // Action for one sample: agree -> idle, disagree below limit -> count,
   // disagree at or past limit -> flip the output.
   function automatic vsep_act_e vsep_decide(input logic differs, input logic reached);
      if (!differs)     return ACT_IDLE;
      else if (reached) return ACT_FLIP;
      else              return ACT_COUNT;
   endfunction

endpackage

// File: rtl/vsep_sync_chain.sv
`timescale 1ns/1ps
module vsep_sync_chain #(
   parameter int unsigned STAGES = 2,
   parameter logic        INIT   = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("vsep_sync_chain: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] stage;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage <= {STAGES{INIT}};
      else        stage <= {stage[STAGES-2:0], d};
   end

   assign q = stage[STAGES-1];
endmodule

// File: rtl/vsep_run_counter.sv
`timescale 1ns/1ps
module vsep_run_counter
   import vsep_pkg::*;
#(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             differs,
   input  logic [CNT_W-1:0] limit,
   output vsep_act_e        act,
   output logic [CNT_W-1:0] cnt
);
   generate
      if (CNT_W < 1 || CNT_W > 16) begin : g_bad_width
         $error("vsep_run_counter: CNT_W must lie in 1..16");
      end
   endgenerate

   localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   logic reached;

   // >= rather than == so a lowered limit cannot strand the count
   assign reached = (cnt >= limit);
   assign act     = vsep_decide(differs, reached);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else begin
         unique case (act)
            ACT_COUNT: cnt <= cnt + ONE;
            default:   cnt <= '0;
         endcase
      end
   end
endmodule

// File: rtl/vsync_separator.sv
`timescale 1ns/1ps
module vsync_separator
   import vsep_pkg::*;
#(
   parameter int unsigned THR_W       = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic        OUT_INIT    = 1'b0
) (
   input  logic             clk_sample,
   input  logic             rst_n,
   input  logic             sync_raw,
   input  logic [THR_W-1:0] thr_cycles,
   output logic             vsync_out
);
   logic             sync_s;
   logic [THR_W-1:0] run_cnt;
   vsep_act_e        act;

   vsep_sync_chain #(
      .STAGES (SYNC_STAGES),
      .INIT   (OUT_INIT)
   ) u_sync (
      .clk   (clk_sample),
      .rst_n (rst_n),
      .d     (sync_raw),
      .q     (sync_s)
   );

   vsep_run_counter #(
      .CNT_W (THR_W)
   ) u_run (
      .clk     (clk_sample),
      .rst_n   (rst_n),
      .differs (sync_s != vsync_out),
      .limit   (thr_cycles),
      .act     (act),
      .cnt     (run_cnt)
   );

   always_ff @(posedge clk_sample or negedge rst_n) begin
      if (!rst_n)               vsync_out <= OUT_INIT;
      else if (act == ACT_FLIP) vsync_out <= sync_s;
   end
endmodule

// File: rtl/vsep_checker.sv
`timescale 1ns/1ps
module vsep_checker #(
   parameter int unsigned THR_W    = 8,
   parameter logic        OUT_INIT = 1'b0
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sync_s,
   input logic [THR_W-1:0] thr,
   input logic [THR_W-1:0] cnt,
   input logic             vs_out
);
   AST_RESET_STATE: assert property (@(posedge clk)
      $rose(rst_n) |-> (vs_out == OUT_INIT && cnt == '0)); // R1

   AST_FLIP_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_s != vs_out && cnt >= thr) |=> (vs_out == $past(sync_s) && cnt == '0)); // R3

   AST_HOLD_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_s != vs_out && cnt < thr) |=> $stable(vs_out)); // R4

   AST_AGREE_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_s == vs_out) |=> (cnt == '0 && $stable(vs_out))); // R6

   AST_COUNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt > thr) |=> (cnt == '0)); // R8
endmodule

bind vsync_separator vsep_checker #(
   .THR_W    (THR_W),
   .OUT_INIT (OUT_INIT)
) u_vsep_chk (
   .clk    (clk_sample),
   .rst_n  (rst_n),
   .sync_s (sync_s),
   .thr    (thr_cycles),
   .cnt    (run_cnt),
   .vs_out (vsync_out)
);

// File: tb/vsync_separator_bench.sv
`timescale 1ns/1ps
module vsync_separator_bench;
   localparam int SYNC_STAGES = 2;

   logic       clk_sample = 1'b0;
   logic       rst_n      = 1'b0;
   logic       sync_raw   = 1'b0;
   logic [7:0] thr_cycles = 8'd32;
   logic       vsync_out;

   int cyc     = 0;
   int checks  = 0;
   int errors  = 0;
   bit done    = 0;

   // model state
   bit cur_raw   = 0;
   bit model_out = 0;
   int run_start = 0;

   // scoreboard of expected output edges
   int    q_cyc[$];
   bit    q_lvl[$];
   string q_tag[$];
   bit    prev_out = 0;

   always #10 clk_sample = ~clk_sample;   // 50 MHz
   always @(posedge clk_sample) cyc <= cyc + 1;

   vsync_separator u_vsync_separator (
      .clk_sample (clk_sample),
      .rst_n      (rst_n),
      .sync_raw   (sync_raw),
      .thr_cycles (thr_cycles),
      .vsync_out  (vsync_out)
   );

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   // Driver: hold raw level for n sample periods, push expected output edge.
   task automatic hold(input bit level, input int n, input string tag);
      int c;
      c = cyc;
      sync_raw = level;
      if (level != cur_raw) begin
         run_start = c;
         cur_raw   = level;
      end
      if (level != model_out && (c + n - run_start) > int'(thr_cycles)) begin
         q_cyc.push_back(run_start + SYNC_STAGES + 1 + int'(thr_cycles));
         q_lvl.push_back(level);
         q_tag.push_back(tag);
         model_out = level;
      end
      repeat (n) @(negedge clk_sample);
   endtask

   task automatic check_level(input string tag);
      check(vsync_out == model_out, tag, "settled level", vsync_out, model_out);
   endtask

   task automatic set_thr(input int t);
      thr_cycles = t[7:0];
   endtask

   // Monitor: pop expected edges as the design produces them.
   always @(negedge clk_sample) begin
      if (rst_n && !done) begin
         if (vsync_out !== prev_out) begin
            if (q_cyc.size() == 0) begin
               check(0, "R4", "unexpected output edge at cycle", cyc, -1);
            end else begin
               int    ec;
               bit    el;
               string et;
               ec = q_cyc.pop_front();
               el = q_lvl.pop_front();
               et = q_tag.pop_front();
               check(cyc == ec, et, "edge cycle", cyc, ec);
               check(vsync_out == el, et, "edge level", vsync_out, el);
            end
         end
         prev_out = vsync_out;
      end
   end

   initial begin
      repeat (5) @(negedge clk_sample);
      check(vsync_out == 1'b0, "R1", "output in reset", vsync_out, 0);
      rst_n = 1'b1;
      hold(0, 10, "R1");
      check_level("R1");

      // R2: zero threshold, follows input two stages later
      set_thr(0);
      hold(1, 1, "R2");
      hold(0, 1, "R2");
      hold(1, 2, "R2");
      hold(0, 6, "R2");
      check_level("R2");

      // R4: horizontal-like pulses well under the threshold
      set_thr(32);
      for (int i = 0; i < 4; i++) begin
         hold(1, 20, "R4");
         hold(0, 40, "R4");
      end
      hold(1, 32, "R4");        // exactly T: rejected
      hold(0, 40, "R4");
      check_level("R4");

      // R5 / R3: T+1 passes, both polarities
      hold(1, 33, "R5");
      hold(1, 10, "R3");
      hold(0, 32, "R4");        // low-going, exactly T: rejected
      hold(1, 10, "R4");
      hold(0, 33, "R5");
      hold(0, 40, "R3");
      check_level("R5");

      // R6: pulses split by one-period gaps do not accumulate
      set_thr(10);
      hold(1, 8, "R6");
      hold(0, 1, "R6");
      hold(1, 8, "R6");
      hold(0, 1, "R6");
      hold(1, 8, "R6");
      hold(0, 20, "R6");
      check_level("R6");

      // R7: each direction needs its own T+1 after a flip
      hold(1, 11, "R7");
      hold(0, 10, "R7");        // rejected
      hold(1, 5, "R7");
      hold(0, 11, "R7");
      hold(1, 11, "R7");
      hold(0, 20, "R7");
      check_level("R7");

      // R8: full range threshold
      set_thr(255);
      hold(1, 255, "R8");       // rejected
      hold(0, 10, "R8");
      hold(1, 256, "R8");       // accepted
      hold(1, 5, "R8");
      hold(0, 300, "R8");
      check_level("R8");

      repeat (20) @(negedge clk_sample);
      check(q_cyc.size() == 0, "R3", "missing output edges", q_cyc.size(), 0);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk_sample);
      if (!done) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule